// File: doc/BRIEF.md
# Latched 16-bit interval timer pair

This block holds two down-counting interval timers that a host reaches one byte at a time through six register offsets. Both timers step on a one-cycle tick enable. In the target system the tick comes from a divide-by-six prescaler on a 4.7 MHz base clock. Timer 1 keeps a 16-bit reload latch. It counts down through zero to all-ones and then reloads, so its period is the latch value plus two ticks. In free-running mode it requests an interrupt each time it reaches zero. Timer 2 is armed by a write to its high byte. It counts down without reloading and requests its interrupt once, the first time it reaches zero after that load.

The block does not hold the interrupt flag register itself. It sends one-cycle set and clear pulses for each timer's flag to a neighbouring flag register. A clear pulse is a side effect of certain byte reads and writes. A set pulse is a counter event. Read data comes straight from the register offset, with no wait state. The timer 1 mode comes from bits 7:6 of the neighbouring auxiliary control register.

Top module: `ivt_pair`

## Requirements
- R1: Timer 1 steps down by one on each tick. After the tick that moves it from 0 to 0xFFFF, the next tick reloads it from its 16-bit latch, so one period is latch + 2 ticks. Without a tick and without a load it holds its value.
- R2: `t1_irq_set` is high for one cycle, in the cycle after a tick that brings the timer 1 counter to 0. This covers both a step down from 1 and a reload from a latch of 0. It fires only while `t1_mode` is 2'b01 (free-running).
- R3: A write to offset 4 or offset 6 replaces only the low byte of the timer 1 latch. The counter and the latch high byte keep their values.
- R4: A write to offset 5 sets the latch high byte to the written value and loads the counter with {written byte, latch low byte}, visible in the next cycle. It pulses `t1_irq_clr` in the cycle of the strobe. A load wins over a tick in the same cycle.
- R5: A write to offset 7 sets the latch high byte and pulses `t1_irq_clr`. It does not reload the counter.
- R6: `rd_data` shows the selected byte in the same cycle. Offset 4 gives the timer 1 counter low byte and offset 5 its high byte. Offsets 6 and 7 give the timer 1 latch low and high bytes. Offsets 8 and 9 give the timer 2 counter low and high bytes. Any other offset reads 0. A read strobe at offset 4 pulses `t1_irq_clr`; a read at offset 5 does not.
- R7: A write to offset 8 stores the timer 2 low latch byte. A write to offset 9 loads the timer 2 counter with {written byte, low latch} in the next cycle. Timer 2 steps down on every tick and wraps from 0 to 0xFFFF without reloading.
- R8: `t2_irq_set` is high for one cycle after the tick that brings timer 2 to 0 for the first time after an offset-9 load. Later passes through 0 give no pulse until the next load.
- R9: A read strobe at offset 8 pulses `t2_irq_clr` and leaves `t1_irq_clr` low.
- R10: After reset, the timer 1 latch and counter are 0xFFFF, the timer 2 counter is 0xFFFF, the timer 2 low latch is 0, and all four pulse outputs are low.
- R11: Read and write strobes at offsets outside 4 to 9 change no counter or latch and produce no clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle prescaled count enable |
| reg_sel | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe for the selected offset |
| rd_en | input | 1 | Read strobe for the selected offset (side effects only) |
| wr_data | input | 8 | Write byte |
| t1_mode | input | 2 | Timer 1 mode field, 2'b01 = free-running with interrupts |
| rd_data | output | 8 | Read byte for the selected offset |
| t1_irq_set | output | 1 | Pulse: set the timer 1 flag |
| t1_irq_clr | output | 1 | Pulse: clear the timer 1 flag |
| t2_irq_set | output | 1 | Pulse: set the timer 2 flag |
| t2_irq_clr | output | 1 | Pulse: clear the timer 2 flag |

## Verification
The bench builds the block with its default values: a 16-bit counter and a 4-bit offset select. With small latch values (0, 3), the zero crossing, the all-ones step and the reload of timer 1 each show up within a few ticks. The latch-of-zero case gives a two-tick period. Timer 2 is driven through a full 65536-tick wrap after it fires, to show that it fires only once. A cycle that carries both a load and a tick is also exercised.

// File: rtl/ivt_pkg.sv
// Shared constants and types for the interval timer pair.
// Assumes a host that decodes offsets on a 4-bit select.
package ivt_pkg;

    // Register offsets; the neighbouring decoder relies on these positions
    localparam int OFS_T1_CLO = 4;
    localparam int OFS_T1_CHI = 5;
    localparam int OFS_T1_LLO = 6;
    localparam int OFS_T1_LHI = 7;
    localparam int OFS_T2_LO  = 8;
    localparam int OFS_T2_HI  = 9;

    // Timer 1 mode field (auxiliary control bits 7:6)
    typedef enum logic [1:0] {
        T1M_ONESHOT  = 2'b00,
        T1M_FREERUN  = 2'b01,
        T1M_PULSE_A  = 2'b10,
        T1M_PULSE_B  = 2'b11
    } t1_mode_e;

    // Decoded write strobes
    typedef struct packed {
        logic t1_lat_lo;   // offset 4 or 6
        logic t1_cnt_hi;   // offset 5
        logic t1_lat_hi;   // offset 7
        logic t2_lat_lo;   // offset 8
        logic t2_cnt_hi;   // offset 9
    } wr_strobe_t;

endpackage

// File: rtl/ivt_regdec.sv
// Offset decoder: turns the select and strobes into per-register write
// strobes and the flag-clear side effects of reads and writes.
// Assumes at most one offset is selected per cycle.
module ivt_regdec
    import ivt_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [SEL_W-1:0] sel_i,
    output wr_strobe_t       wr_o,
    output logic             t1_clr_o,
    output logic             t2_clr_o
);

    // Per-offset hit terms
    logic hit_clo, hit_chi, hit_llo, hit_lhi, hit_t2lo, hit_t2hi;

    // Compare the select against each timer offset
    always_comb begin
        hit_clo  = (sel_i == SEL_W'(OFS_T1_CLO));
        hit_chi  = (sel_i == SEL_W'(OFS_T1_CHI));
        hit_llo  = (sel_i == SEL_W'(OFS_T1_LLO));
        hit_lhi  = (sel_i == SEL_W'(OFS_T1_LHI));
        hit_t2lo = (sel_i == SEL_W'(OFS_T2_LO));
        hit_t2hi = (sel_i == SEL_W'(OFS_T2_HI));
    end

    // Build write strobes; both timer 1 low offsets hit the latch low byte
    always_comb begin
        wr_o.t1_lat_lo = wr_en_i && (hit_clo || hit_llo);
        wr_o.t1_cnt_hi = wr_en_i && hit_chi;
        wr_o.t1_lat_hi = wr_en_i && hit_lhi;
        wr_o.t2_lat_lo = wr_en_i && hit_t2lo;
        wr_o.t2_cnt_hi = wr_en_i && hit_t2hi;
    end

    // Flag-clear side effects
    always_comb begin
        t1_clr_o = (wr_en_i && (hit_chi || hit_lhi)) || (rd_en_i && hit_clo);
        t2_clr_o = rd_en_i && hit_t2lo;
    end

endmodule

// File: rtl/ivt_reload_timer.sv
// Timer 1: down counter with a reload latch. It steps from 0 to all-ones,
// then reloads on the next tick, so a period is latch + 2 ticks. The set
// pulse is registered and appears in the cycle after the tick that makes
// the counter zero, in free-running mode only.
// Assumes at most one write strobe per cycle; a load takes priority over
// a tick.
module ivt_reload_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_lat_lo_i,
    input  logic             wr_lat_hi_i,
    input  logic             wr_cnt_hi_i,
    input  logic [CNT_W/2-1:0] data_i,
    input  logic [1:0]       mode_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] latch_o,
    output logic             set_o
);

    localparam int BYTE_W = CNT_W / 2;
    localparam logic [CNT_W-1:0] ONES = '1;
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, latch_q;
    logic             wrap_q;   // counter has just passed below zero
    logic             set_q;
    logic             freerun;

    // Decode the mode field
    always_comb freerun = (mode_i == T1M_FREERUN);

    // Latch byte updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= ONES;
        end else begin
            if (wr_lat_lo_i)
                latch_q[BYTE_W-1:0] <= data_i;
            if (wr_lat_hi_i || wr_cnt_hi_i)
                latch_q[CNT_W-1:BYTE_W] <= data_i;
        end
    end

    // Counter, wrap marker and set pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= ONES;
            wrap_q <= 1'b0;
            set_q  <= 1'b0;
        end else begin
            set_q <= 1'b0;
            if (wr_cnt_hi_i) begin
                cnt_q  <= {data_i, latch_q[BYTE_W-1:0]};
                wrap_q <= 1'b0;
            end else if (tick_i) begin
                if (wrap_q) begin
                    cnt_q  <= latch_q;
                    wrap_q <= 1'b0;
                    set_q  <= freerun && (latch_q == ZERO);
                end else begin
                    cnt_q  <= cnt_q - ONE;
                    wrap_q <= (cnt_q == ZERO);
                    set_q  <= freerun && (cnt_q == ONE);
                end
            end
        end
    end

    assign cnt_o   = cnt_q;
    assign latch_o = latch_q;
    assign set_o   = set_q;

    AST_T1_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_cnt_hi_i && !wrap_q && cnt_q == ZERO) |=> (cnt_q == ONES)); // R1
    AST_T1_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_cnt_hi_i && wrap_q) |=> (cnt_q == $past(latch_q))); // R1
    AST_T1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_cnt_hi_i) |=> $stable(cnt_q)); // R1
    AST_T1_SET_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        set_o |-> (cnt_q == ZERO && $past(mode_i) == T1M_FREERUN)); // R2
    AST_T1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_hi_i |=> (cnt_q == {$past(data_i), $past(latch_q[BYTE_W-1:0])})); // R4
    AST_T1_LHI_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lat_hi_i && !tick_i) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/ivt_oneshot_timer.sv
// Timer 2: down counter loaded from {high byte written, low latch}. It
// wraps freely and gives a single registered set pulse the first time it
// reaches zero after a load.
// Assumes at most one write strobe per cycle; a load takes priority over
// a tick.
module ivt_oneshot_timer #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               wr_lat_lo_i,
    input  logic               wr_cnt_hi_i,
    input  logic [CNT_W/2-1:0] data_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               set_o
);

    localparam int BYTE_W = CNT_W / 2;
    localparam logic [CNT_W-1:0] ONES = '1;
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [BYTE_W-1:0] latch_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              armed_q;
    logic              set_q;

    // Low latch byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (wr_lat_lo_i)
            latch_q <= data_i;
    end

    // Counter, arm bit and one-shot set pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= ONES;
            armed_q <= 1'b0;
            set_q   <= 1'b0;
        end else begin
            set_q <= 1'b0;
            if (wr_cnt_hi_i) begin
                cnt_q   <= {data_i, latch_q};
                armed_q <= 1'b1;
            end else if (tick_i) begin
                cnt_q <= cnt_q - ONE;
                if (armed_q && cnt_q == ONE) begin
                    set_q   <= 1'b1;
                    armed_q <= 1'b0;
                end
            end
        end
    end

    assign cnt_o = cnt_q;
    assign set_o = set_q;

    AST_T2_SET_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        set_o |-> (cnt_q == ZERO)); // R8
    AST_T2_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_hi_i |=> (cnt_q == {$past(data_i), $past(latch_q)})); // R7
    AST_T2_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lat_lo_i |=> $stable(latch_q)); // R7
    AST_T2_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_cnt_hi_i && cnt_q == ZERO) |=> (cnt_q == ONES)); // R7

endmodule

// File: rtl/ivt_rdmux.sv
// Read multiplexer: picks the byte for the selected offset, with no wait
// state. Unmapped offsets read as zero.
// Assumes both counters share one width.
module ivt_rdmux
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [CNT_W-1:0]   t1_cnt_i,
    input  logic [CNT_W-1:0]   t1_lat_i,
    input  logic [CNT_W-1:0]   t2_cnt_i,
    output logic [CNT_W/2-1:0] data_o
);

    localparam int BYTE_W = CNT_W / 2;

    // Byte selection by offset
    always_comb begin
        data_o = '0;
        if      (sel_i == SEL_W'(OFS_T1_CLO)) data_o = t1_cnt_i[BYTE_W-1:0];
        else if (sel_i == SEL_W'(OFS_T1_CHI)) data_o = t1_cnt_i[CNT_W-1:BYTE_W];
        else if (sel_i == SEL_W'(OFS_T1_LLO)) data_o = t1_lat_i[BYTE_W-1:0];
        else if (sel_i == SEL_W'(OFS_T1_LHI)) data_o = t1_lat_i[CNT_W-1:BYTE_W];
        else if (sel_i == SEL_W'(OFS_T2_LO))  data_o = t2_cnt_i[BYTE_W-1:0];
        else if (sel_i == SEL_W'(OFS_T2_HI))  data_o = t2_cnt_i[CNT_W-1:BYTE_W];
    end

endmodule

// File: rtl/ivt_pair.sv
// Top of the interval timer pair: decoder, two timers and read mux.
// Set and clear pulses go to an external flag register. Both pulses for
// one flag may be high in the same cycle; the flag register decides the
// priority.
// Assumes tick_en is a one-cycle prescaled enable.
module ivt_pair
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic [1:0]         t1_mode,
    output logic [CNT_W/2-1:0] rd_data,
    output logic               t1_irq_set,
    output logic               t1_irq_clr,
    output logic               t2_irq_set,
    output logic               t2_irq_clr
);

    wr_strobe_t       wr_s;
    logic [CNT_W-1:0] t1_cnt, t1_lat, t2_cnt;

    // Offset decode and side-effect clears
    ivt_regdec #(.SEL_W(SEL_W)) u_dec (
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .sel_i   (reg_sel),
        .wr_o    (wr_s),
        .t1_clr_o(t1_irq_clr),
        .t2_clr_o(t2_irq_clr)
    );

    // Timer 1
    ivt_reload_timer #(.CNT_W(CNT_W)) u_t1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_en),
        .wr_lat_lo_i(wr_s.t1_lat_lo),
        .wr_lat_hi_i(wr_s.t1_lat_hi),
        .wr_cnt_hi_i(wr_s.t1_cnt_hi),
        .data_i     (wr_data),
        .mode_i     (t1_mode),
        .cnt_o      (t1_cnt),
        .latch_o    (t1_lat),
        .set_o      (t1_irq_set)
    );

    // Timer 2
    ivt_oneshot_timer #(.CNT_W(CNT_W)) u_t2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_en),
        .wr_lat_lo_i(wr_s.t2_lat_lo),
        .wr_cnt_hi_i(wr_s.t2_cnt_hi),
        .data_i     (wr_data),
        .cnt_o      (t2_cnt),
        .set_o      (t2_irq_set)
    );

    // Read data
    ivt_rdmux #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_rd (
        .sel_i   (reg_sel),
        .t1_cnt_i(t1_cnt),
        .t1_lat_i(t1_lat),
        .t2_cnt_i(t2_cnt),
        .data_o  (rd_data)
    );

    AST_CLR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_irq_clr || t2_irq_clr) |-> (wr_en || rd_en)); // R11

endmodule

// File: tb/ivt_pair_bench.sv
// Directed bench for the interval timer pair. Inputs change on the falling
// edge; outputs are sampled away from the rising edge.
module ivt_pair_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] reg_sel = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] t1_mode = 2'b00;
    logic [7:0] rd_data;
    logic       t1_irq_set, t1_irq_clr, t2_irq_set, t2_irq_clr;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    // Values captured by the stimulus tasks
    logic c_t1clr, c_t2clr, c_t1set, c_t2set;
    logic [7:0] c_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivt_pair u_ivt_pair (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_sel(reg_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .t1_mode(t1_mode),
        .rd_data(rd_data), .t1_irq_set(t1_irq_set), .t1_irq_clr(t1_irq_clr),
        .t2_irq_set(t2_irq_set), .t2_irq_clr(t2_irq_clr)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d, input bit tk = 0);
        @(negedge clk);
        reg_sel = s; wr_data = d; wr_en = 1'b1; tick_en = tk;
        #1 c_t1clr = t1_irq_clr; c_t2clr = t2_irq_clr;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s);
        @(negedge clk);
        reg_sel = s; rd_en = 1'b1;
        #1 c_rd = rd_data; c_t1clr = t1_irq_clr; c_t2clr = t2_irq_clr;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        #1 c_t1set = t1_irq_set; c_t2set = t2_irq_set;
    endtask

    task automatic peek16(input logic [3:0] lo, output logic [15:0] v);
        reg_sel = lo; #1 v[7:0] = rd_data;
        reg_sel = lo + 4'd1; #1 v[15:8] = rd_data;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        @(negedge clk);
        chk("R10", "t1_irq_set", {15'd0, t1_irq_set}, 16'd0);
        chk("R10", "t2_irq_set", {15'd0, t2_irq_set}, 16'd0);
        peek16(4'd4, v); chk("R10", "t1 counter", v, 16'hFFFF);
        peek16(4'd6, v); chk("R10", "t1 latch", v, 16'hFFFF);
        peek16(4'd8, v); chk("R10", "t2 counter", v, 16'hFFFF);
        wr(4'd9, 8'hAB);
        peek16(4'd8, v); chk("R10", "t2 low latch zero", v, 16'hAB00);
    endtask

    task automatic t_t1_period();
        logic [15:0] v;
        t1_mode = 2'b01;
        wr(4'd6, 8'h03);
        wr(4'd7, 8'h00);
        chk("R5", "clr on latch-high write", {15'd0, c_t1clr}, 16'd1);
        peek16(4'd4, v); chk("R5", "no reload", v, 16'hFFFF);
        wr(4'd5, 8'h00);
        chk("R4", "clr on counter-high write", {15'd0, c_t1clr}, 16'd1);
        peek16(4'd4, v); chk("R4", "loaded", v, 16'h0003);
        tick(); tick();
        chk("R2", "no set at 1", {15'd0, c_t1set}, 16'd0);
        tick();
        chk("R2", "set at zero", {15'd0, c_t1set}, 16'd1);
        peek16(4'd4, v); chk("R1", "at zero", v, 16'h0000);
        tick();
        peek16(4'd4, v); chk("R1", "past zero", v, 16'hFFFF);
        chk("R2", "no set at ffff", {15'd0, c_t1set}, 16'd0);
        tick();
        peek16(4'd4, v); chk("R1", "reload after latch+2", v, 16'h0003);
        repeat (3) @(negedge clk);
        peek16(4'd4, v); chk("R1", "hold without tick", v, 16'h0003);
    endtask

    task automatic t_t1_mode_gate();
        logic [15:0] v;
        bit seen = 0;
        t1_mode = 2'b00;
        repeat (3) begin tick(); if (c_t1set) seen = 1; end
        peek16(4'd4, v); chk("R2", "counts in mode 00", v, 16'h0000);
        chk("R2", "no set in mode 00", {15'd0, seen}, 16'd0);
        tick(); tick();
        peek16(4'd4, v); chk("R1", "reload in mode 00", v, 16'h0003);
    endtask

    task automatic t_t1_latch_zero();
        logic [15:0] v;
        t1_mode = 2'b01;
        wr(4'd6, 8'h00);
        wr(4'd5, 8'h00);
        tick();
        peek16(4'd4, v); chk("R1", "latch0 ffff", v, 16'hFFFF);
        chk("R2", "latch0 no set at ffff", {15'd0, c_t1set}, 16'd0);
        tick();
        peek16(4'd4, v); chk("R1", "latch0 reload", v, 16'h0000);
        chk("R2", "latch0 set on reload", {15'd0, c_t1set}, 16'd1);
        tick(); tick();
        chk("R2", "latch0 period 2", {15'd0, c_t1set}, 16'd1);
    endtask

    task automatic t_t1_bytes();
        logic [15:0] v;
        wr(4'd6, 8'h34);
        wr(4'd5, 8'h12);
        wr(4'd4, 8'h55);
        peek16(4'd4, v); chk("R3", "counter untouched", v, 16'h1234);
        peek16(4'd6, v); chk("R3", "latch low only", v, 16'h1255);
        rd(4'd4);
        chk("R6", "read cnt lo", {8'd0, c_rd}, 16'h0034);
        chk("R6", "clr on cnt lo read", {15'd0, c_t1clr}, 16'd1);
        rd(4'd5);
        chk("R6", "read cnt hi", {8'd0, c_rd}, 16'h0012);
        chk("R6", "no clr on cnt hi read", {15'd0, c_t1clr}, 16'd0);
        rd(4'd7);
        chk("R6", "read latch hi", {8'd0, c_rd}, 16'h0012);
        wr(4'd5, 8'h20, 1);
        peek16(4'd4, v); chk("R4", "load wins over tick", v, 16'h2055);
    endtask

    task automatic t_t2();
        logic [15:0] v;
        bit seen = 0;
        t1_mode = 2'b00;
        wr(4'd8, 8'h02);
        wr(4'd9, 8'h00);
        peek16(4'd8, v); chk("R7", "t2 load", v, 16'h0002);
        tick();
        chk("R8", "t2 no set at 1", {15'd0, c_t2set}, 16'd0);
        tick();
        chk("R8", "t2 set at zero", {15'd0, c_t2set}, 16'd1);
        tick();
        peek16(4'd8, v); chk("R7", "t2 wraps", v, 16'hFFFF);
        rd(4'd8);
        chk("R9", "t2 clr on low read", {15'd0, c_t2clr}, 16'd1);
        chk("R9", "t1 clr quiet", {15'd0, c_t1clr}, 16'd0);
        @(negedge clk);
        tick_en = 1'b1;
        for (int i = 0; i < 65535; i++) begin
            @(negedge clk);
            #1 if (t2_irq_set) seen = 1;
        end
        tick_en = 1'b0;
        peek16(4'd8, v); chk("R7", "t2 second zero", v, 16'h0000);
        chk("R8", "t2 fires once", {15'd0, seen}, 16'd0);
    endtask

    task automatic t_unmapped();
        logic [15:0] a0, a1, a2, b0, b1, b2;
        peek16(4'd4, a0); peek16(4'd6, a1); peek16(4'd8, a2);
        wr(4'd3, 8'h77);
        chk("R11", "no clr on offset 3", {14'd0, c_t1clr, c_t2clr}, 16'd0);
        wr(4'd10, 8'h77);
        rd(4'd2);
        chk("R6", "unmapped reads zero", {8'd0, c_rd}, 16'h0000);
        chk("R11", "no clr on read 2", {14'd0, c_t1clr, c_t2clr}, 16'd0);
        peek16(4'd4, b0); peek16(4'd6, b1); peek16(4'd8, b2);
        chk("R11", "t1 counter kept", b0, a0);
        chk("R11", "t1 latch kept", b1, a1);
        chk("R11", "t2 counter kept", b2, a2);
    endtask

    // Main sequence
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_t1_period();
        t_t1_mode_gate();
        t_t1_latch_zero();
        t_t1_bytes();
        t_t2();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule